// File: doc/BRIEF.md
# Shift Unit with Carry Output

A combinational 32-bit shifter of the sort that sits inside a processor's arithmetic unit. It receives an operand, a shift count and a two-bit operation code. It returns the shifted word together with a carry bit. The carry bit is the last bit that left the word, or a fixed bit of the operand when the count is zero.

Four operations are provided: logical left, logical right, arithmetic right, and an arithmetic-left variant. The arithmetic-left variant fills the vacated low positions with copies of the operand's original least significant bit. Only the low five bits of the count are used.

The datapath folds both right shifts into the left-shift path by reversing the bit order on entry and exit. One logarithmic shifter therefore serves all four operations. That shifter carries one extra bit position, which produces the carry.

Top module: `shift_unit`

## Requirements
- R1: Only the low 5 bits of `amount_i` set the shift count s (0..31); all higher bits of `amount_i` have no effect on `result_o` or `carry_o`.
- R2: With `op_i` = 2'b00 (logical left), `result_o` is the operand moved s places toward the MSB with zeros entering at bit 0.
- R3: With `op_i` = 2'b01 (arithmetic left), `result_o` is the operand moved s places toward the MSB with copies of the original operand bit 0 entering the low s positions. For example, 0x12345679 by 4 gives 0x2345679F and 0x12345678 by 4 gives 0x23456780.
- R4: With `op_i` = 2'b10 (logical right), `result_o` is the operand moved s places toward the LSB with zeros entering at bit 31.
- R5: With `op_i` = 2'b11 (arithmetic right), `result_o` is the operand moved s places toward the LSB with copies of the original operand bit 31 entering the high s positions.
- R6: For both left operations, `carry_o` equals operand bit 32−s when s > 0, and equals operand bit 31 when s = 0.
- R7: For both right operations, `carry_o` equals operand bit s−1 when s > 0, and equals operand bit 0 when s = 0.
- R8: When s = 0, `result_o` equals the operand for every operation code.
- R9: The operation code is decoded as 00 logical left, 01 arithmetic left, 10 logical right, 11 arithmetic right. Bit 1 of the code selects the right direction, and bit 0 selects the arithmetic fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Word to be shifted |
| amount_i | input | 32 | Shift count; only bits [4:0] are used |
| op_i | input | 2 | Operation code (see R9) |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Last bit shifted out, or the zero-count fallback bit |

## Verification
The block holds no state, so `result_o` and `carry_o` are due in the same cycle as the inputs that produce them, once the combinational paths have settled. The bench drives each new operand, count and code just after a rising clock edge. It compares both outputs at the following falling edge, half a period later, so no register delay needs to be counted. Every sample is taken well after the inputs have changed.

// File: rtl/shift_unit_pkg.sv
// Package: shared operation encoding for the shift unit.
// Assumes the two-bit code layout: bit 1 = right direction, bit 0 = arithmetic fill.
package shift_unit_pkg;

    typedef enum logic [1:0] {
        OP_LSL = 2'b00,
        OP_ASL = 2'b01,
        OP_LSR = 2'b10,
        OP_ASR = 2'b11
    } shift_op_e;

    // Returns 1 when the code selects a right-going shift.
    function automatic logic op_is_right(input logic [1:0] op);
        return op[1];
    endfunction

    // Returns 1 when the code selects a fill taken from the operand.
    function automatic logic op_is_arith(input logic [1:0] op);
        return op[0];
    endfunction

endpackage

// File: rtl/shift_bit_reverse.sv
// Module: shift_bit_reverse
// Mirrors the bit order of a word (bit i goes to bit W-1-i).
// Assumes nothing about the contents; pure wiring.
module shift_bit_reverse #(
    parameter int W = 32
) (
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);

    // Wire each output bit to its mirrored input bit.
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign out_o[i] = in_i[W-1-i];
    end

endmodule

// File: rtl/shift_log_left.sv
// Module: shift_log_left
// Logarithmic left shifter over a W+1 bit vector. The extra top bit starts as
// vec_i[W-1] and after shifting by s>0 holds vec_i[W-s], the last bit out.
// The low s positions take fill_i. Assumes W is a power of two and sh_i < W.
module shift_log_left #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   vec_i,
    input  logic [SHW-1:0] sh_i,
    input  logic           fill_i,
    output logic [W-1:0]   vec_o,
    output logic           out_bit_o
);

    localparam int VW = W + 1;

    logic [VW-1:0] stg [0:SHW];

    // Seed the chain: the spare top bit carries the zero-count fallback.
    assign stg[0] = {vec_i[W-1], vec_i};

    // Each stage moves the vector by 2**k when count bit k is set.
    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stg[k+1] = sh_i[k] ? {stg[k][VW-1-STEP:0], {STEP{fill_i}}}
                                  : stg[k];
    end

    // Split the final vector into the carry bit and the word.
    assign out_bit_o = stg[SHW][W];
    assign vec_o     = stg[SHW][W-1:0];

endmodule

// File: rtl/shift_unit.sv
// Module: shift_unit (top)
// Combinational shifter: logical/arithmetic left and right with carry out.
// Right shifts reuse the left shifter by mirroring the word on entry and exit.
// Assumes WIDTH is a power of two and AMT_W >= $clog2(WIDTH).
module shift_unit
    import shift_unit_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = 32
) (
    input  logic [WIDTH-1:0] operand_i,
    input  logic [AMT_W-1:0] amount_i,
    input  logic [1:0]       op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o
);

    localparam int SHW = $clog2(WIDTH);

    logic [SHW-1:0]   shamt;
    logic [WIDTH-1:0] operand_rev;
    logic [WIDTH-1:0] norm_in;
    logic             fill_bit;
    logic [WIDTH-1:0] core_out;
    logic [WIDTH-1:0] core_rev;
    logic             core_carry;
    logic             unused_amt_hi;

    // Keep only the low count bits; the rest are deliberately dropped.
    assign shamt         = amount_i[SHW-1:0];
    assign unused_amt_hi = ^amount_i;

    shift_bit_reverse #(.W(WIDTH)) u_rev_in (
        .in_i  (operand_i),
        .out_o (operand_rev)
    );

    // Choose the left-domain operand: mirrored for right shifts.
    assign norm_in = op_is_right(op_i) ? operand_rev : operand_i;

    // Arithmetic fill is bit 0 of the left-domain word (original bit 0 or 31).
    assign fill_bit = op_is_arith(op_i) & norm_in[0];

    shift_log_left #(.W(WIDTH), .SHW(SHW)) u_core (
        .vec_i     (norm_in),
        .sh_i      (shamt),
        .fill_i    (fill_bit),
        .vec_o     (core_out),
        .out_bit_o (core_carry)
    );

    shift_bit_reverse #(.W(WIDTH)) u_rev_out (
        .in_i  (core_out),
        .out_o (core_rev)
    );

    // Return to natural bit order for right shifts.
    assign result_o = op_is_right(op_i) ? core_rev : core_out;
    assign carry_o  = core_carry;

endmodule

// File: rtl/shift_unit_chk.sv
// Module: shift_unit_chk
// Checker bound to shift_unit: port-level rules on fill, carry and zero count.
// Assumes inputs may be unknown before first drive; checks are gated on known conditions.
module shift_unit_chk #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 32
) (
    input logic [WIDTH-1:0] operand_i,
    input logic [AMT_W-1:0] amount_i,
    input logic [1:0]       op_i,
    input logic [WIDTH-1:0] result_o,
    input logic             carry_o
);

    localparam int SHW = $clog2(WIDTH);

    logic [SHW-1:0] s;
    assign s = amount_i[SHW-1:0];

    // Evaluate the rules whenever any observed signal changes.
    always_comb begin
        if (s == '0)
            assert_zero_passthru_R8: assert (result_o == operand_i);
        if (op_i == 2'b00 && s != '0)
            assert_lsl_low_zero_R2: assert (result_o[0] == 1'b0);
        if (op_i == 2'b01 && s != '0)
            assert_asl_low_fill_R3: assert (result_o[0] == operand_i[0]);
        if (op_i == 2'b10 && s != '0)
            assert_lsr_top_zero_R4: assert (result_o[WIDTH-1] == 1'b0);
        if (op_i == 2'b11)
            assert_asr_top_sign_R5: assert (result_o[WIDTH-1] == operand_i[WIDTH-1]);
        if (op_i[1] == 1'b0 && s == '0)
            assert_left_zero_carry_R6: assert (carry_o == operand_i[WIDTH-1]);
        if (op_i[1] == 1'b1 && s == '0)
            assert_right_zero_carry_R7: assert (carry_o == operand_i[0]);
        if (op_i[1] == 1'b1 && s == SHW'(1))
            assert_right_one_carry_R7: assert (carry_o == operand_i[0]);
    end

endmodule

bind shift_unit shift_unit_chk #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_chk (
    .operand_i (operand_i),
    .amount_i  (amount_i),
    .op_i      (op_i),
    .result_o  (result_o),
    .carry_o   (carry_o)
);

// File: tb/shift_unit_tb.sv
// Bench: sweeps every count and code over a set of operands, model computed
// with 64-bit arithmetic independent of the design's mirroring scheme.
module shift_unit_tb;

    logic        clk = 1'b0;
    logic [31:0] operand;
    logic [31:0] amount;
    logic [1:0]  op;
    logic [31:0] result;
    logic        carry;
    int          n_checks = 0;
    int          n_errors = 0;
    int          cycles   = 0;
    bit          done     = 1'b0;

    always #2.5 clk = ~clk;

    shift_unit u_dut (
        .operand_i (operand),
        .amount_i  (amount),
        .op_i      (op),
        .result_o  (result),
        .carry_o   (carry)
    );

    // Expected {carry, result} from the requirement definitions.
    function automatic logic [32:0] model(input logic [31:0] d, input int s, input logic [1:0] o);
        logic [63:0] w;
        logic [31:0] r;
        logic        c;
        case (o)
            2'b00: begin w = {d, 32'h0} << s;         r = w[63:32]; end
            2'b01: begin w = {d, {32{d[0]}}} << s;    r = w[63:32]; end
            2'b10: begin w = {32'h0, d} >> s;         r = w[31:0];  end
            default: begin w = {{32{d[31]}}, d} >> s; r = w[31:0];  end
        endcase
        if (o[1] == 1'b0) c = (s == 0) ? d[31] : d[32 - s];
        else              c = (s == 0) ? d[0]  : d[s - 1];
        return {c, r};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_errors++;
            $display("FAIL %s: op=%0d d=%h amt=%h actual=%h expected=%h",
                     req, op, operand, amount, act, exp_v);
        end
    endtask

    // Drive after a rising edge, compare at the falling edge.
    task automatic apply(input logic [31:0] d, input logic [31:0] a, input logic [1:0] o);
        logic [32:0] e;
        string rr, rc;
        @(posedge clk);
        operand = d; amount = a; op = o;
        @(negedge clk);
        e = model(d, int'(a[4:0]), o);
        case (o)
            2'b00: rr = "R2 R9";
            2'b01: rr = "R3 R9";
            2'b10: rr = "R4 R9";
            default: rr = "R5 R9";
        endcase
        if (a[31:5] != 0) rr = {rr, " R1"};
        if (a[4:0] == 0)  rr = {rr, " R8"};
        rc = o[1] ? "R7 carry" : "R6 carry";
        check(rr, result, e[31:0]);
        check(rc, {31'h0, carry}, {31'h0, e[32]});
    endtask

    initial begin
        logic [31:0] lfsr;
        logic [31:0] pats [8];
        pats = '{32'h12345678, 32'h12345679, 32'h80000001, 32'hFFFFFFFF,
                 32'h00000000, 32'hA5A5A5A5, 32'h7FFFFFFE, 32'h00000001};
        operand = '0; amount = '0; op = 2'b00;
        @(negedge clk);
        // Idle state with zero inputs.
        check("R8 idle", result, 32'h0);
        check("R6 idle", {31'h0, carry}, 32'h0);

        // Worked examples for the arithmetic-left fill (R3).
        @(posedge clk); operand = 32'h12345679; amount = 32'd4; op = 2'b01;
        @(negedge clk); check("R3 example", result, 32'h2345679F);
        @(posedge clk); operand = 32'h12345678;
        @(negedge clk); check("R3 example", result, 32'h23456780);

        // Full count/code sweep over fixed patterns.
        foreach (pats[p])
            for (int o = 0; o < 4; o++)
                for (int s = 0; s < 32; s++)
                    apply(pats[p], 32'(s), 2'(o));

        // Pseudo-random operands, counts with random upper bits (R1).
        lfsr = 32'hC0FFEE01;
        for (int n = 0; n < 24; n++) begin
            for (int o = 0; o < 4; o++)
                for (int s = 0; s < 32; s++) begin
                    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                    apply(lfsr ^ 32'(n * 32'h9E3779B9), {lfsr[26:0], 5'(s)}, 2'(o));
                end
        end

        // R1: same low count with and without upper bits must match.
        @(posedge clk); operand = 32'hDEADBEEF; amount = 32'h0000_0007; op = 2'b11;
        @(negedge clk); check("R1 base", result, model(32'hDEADBEEF, 7, 2'b11));
        @(posedge clk); amount = 32'hFFFF_FFE7;
        @(negedge clk); check("R1 high bits", result, model(32'hDEADBEEF, 7, 2'b11));
        check("R1 high bits carry", {31'h0, carry}, {31'h0, model(32'hDEADBEEF, 7, 2'b11) >> 32});
        done = 1'b1;
    end

    // Watchdog and single summary point.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (done) begin
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end else if (cycles > 150000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule